// File: doc/BRIEF.md
# Masked Line Configuration Register Bank

This block is a bus-facing register file. It holds the pad configuration of every I/O line in a number of groups. By default there are four groups of 32 lines. Each group has three registers:

- a line mask;
- one configuration word that all lines of the group share;
- a freeze command.

A write to the configuration word reaches only the lines selected in that group's mask. Each selected line then keeps its own copy of the fields. Lines outside the mask keep what they had.

Two per-line freeze flags protect part of each line's configuration:

- The physical freeze protects the function select, direction, pull resistors, open-drain, Schmitt control and drive strength.
- The interrupt freeze protects the input filter enable, the filter clock select and the event select.

Once a flag is set, only a hardware reset clears it. A global write-protect bit rejects every configuration write while it is set. The bank also enforces a pull interlock: a line can only take a pull-down enable in a write that leaves its pull-up off.

A read of a group's configuration word returns the fields and freeze flags of the lowest-numbered masked line in that group. The per-line settings leave the block on flat output vectors, which feed the pad and event logic outside it.

Top module: `cfgbank_top`

## Requirements
- R1: After reset, every line configuration, every freeze flag, every group mask and the write-protect bit are 0.
- R2: The write-protect register sits at byte address 0x100, and its bit 0 is the lock. While the lock reads 1, a write to any configuration word changes no line. The mask and freeze command registers stay writable while the lock is set.
- R3: Group g has its mask at 0x00 + g*0x40 and its configuration word at 0x04 + g*0x40. A configuration write updates exactly the lines whose bit is set in that group's mask. All other lines, in that group and in the other groups, keep their values. The mask reads back as written.
- R4: The configuration word has these fields, which read back as written:
  - function select in bits 2:0
  - direction in bit 8
  - pull-up in bit 9
  - pull-down in bit 10
  - filter enable in bit 12
  - filter slow-clock select in bit 13
  - open-drain in bit 14
  - Schmitt disable in bit 15
  - drive strength in bits 17:16
  - event select in bits 26:24

  Bits 31, 28:27, 23:18, 11 and 7:3 always read 0.
- R5: Bit 29 of the configuration word reads a line's physical freeze flag. While that flag is set, writes leave the line's function, direction, pull-up, pull-down, open-drain, Schmitt and drive-strength fields unchanged, but the filter and event fields still take new values.
- R6: Bit 30 of the configuration word reads a line's interrupt freeze flag. While that flag is set, writes leave the line's filter enable, filter clock select and event select fields unchanged, but the physical fields still take new values.
- R7: The freeze command register sits at 0x08 + g*0x40. Writing it with bit 0 set raises the physical freeze of every masked line in the group, and bit 1 does the same for the interrupt freeze. Writing 0, or writing with an empty mask, changes no flag. No write clears a flag; only reset does.
- R8: A line stores pull-down as 1 only when the same write carries pull-down 1 and pull-up 0. Otherwise the line's stored pull-down becomes 0. No line ever has both pulls enabled.
- R9: A configuration word read returns the lowest-numbered line set in that group's mask. With an empty mask, the read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for addr_i/wdata_i |
| addr_i | input | ADDR_W (9) | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| cfg_o | output | GROUPS*LINES*15 | Per-line fields, line n at bits n*15 +: 15, packed {evt, drv, schmitt_dis, od, flt_slow, flt_en, pd, pu, dir, func} |
| pfrz_o | output | GROUPS*LINES | Physical freeze flag per line (line n = g*LINES + i) |
| ifrz_o | output | GROUPS*LINES | Interrupt freeze flag per line |

## Verification
The masked write is tried in four ways:

- with a single-bit mask;
- with a two-line mask, read back one line at a time;
- with a mask in a neighbouring group;
- with a later overlapping write.

Together these separate a correct per-line update from a broadcast to the group or to the whole bank. Read selection is probed with two lines that hold different values, which shows whether the lowest or the highest masked line is picked, and with an empty mask. The freeze tests write all-ones over a frozen line, so any field that leaks through a freeze shows up in the read data. The pull interlock is tried with pull-down alone, with both pulls set, and with every bit set.

// File: rtl/cfgbank_pkg.sv
`timescale 1ns/1ps
package cfgbank_pkg;

  typedef struct packed {
    logic [2:0] evt;
    logic [1:0] drv;
    logic       st_dis;
    logic       od;
    logic       flt_slow;
    logic       flt_en;
    logic       pd;
    logic       pu;
    logic       dir;
    logic [2:0] func;
  } line_cfg_t;

  localparam int CFG_W = $bits(line_cfg_t);

  // field classes inside line_cfg_t
  localparam logic [CFG_W-1:0] PHYS_FIELDS = 15'h0F3F;
  localparam logic [CFG_W-1:0] IRQ_FIELDS  = 15'h70C0;
  localparam int POS_PU = 4;
  localparam int POS_PD = 5;

  localparam logic [5:0] OFS_MASK = 6'h00;
  localparam logic [5:0] OFS_CFG  = 6'h04;
  localparam logic [5:0] OFS_FRZ  = 6'h08;

  localparam int FRZ_PHYS_BIT = 0;
  localparam int FRZ_IRQ_BIT  = 1;

  localparam logic [31:0] WORD_RSVD = ~32'h6703_F707;

  function automatic line_cfg_t word_to_cfg(logic [31:0] w);
    line_cfg_t c;
    c.func     = w[2:0];
    c.dir      = w[8];
    c.pu       = w[9];
    c.pd       = w[10] & ~w[9];
    c.flt_en   = w[12];
    c.flt_slow = w[13];
    c.od       = w[14];
    c.st_dis   = w[15];
    c.drv      = w[17:16];
    c.evt      = w[26:24];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(logic [CFG_W-1:0] v, logic pf, logic irf);
    line_cfg_t   c;
    logic [31:0] w;
    c         = v;
    w         = '0;
    w[2:0]    = c.func;
    w[8]      = c.dir;
    w[9]      = c.pu;
    w[10]     = c.pd;
    w[12]     = c.flt_en;
    w[13]     = c.flt_slow;
    w[14]     = c.od;
    w[15]     = c.st_dis;
    w[17:16]  = c.drv;
    w[26:24]  = c.evt;
    w[29]     = pf;
    w[30]     = irf;
    return w;
  endfunction

endpackage

// File: rtl/cfgbank_line.sv
`timescale 1ns/1ps
module cfgbank_line
  import cfgbank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cfg_i,
  input  logic [CFG_W-1:0] new_cfg_i,
  input  logic             set_pfrz_i,
  input  logic             set_ifrz_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             pfrz_o,
  output logic             ifrz_o
);

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] lock;
  logic             pfrz_q, ifrz_q;

  assign lock = (pfrz_q ? PHYS_FIELDS : '0) | (ifrz_q ? IRQ_FIELDS : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      pfrz_q <= 1'b0;
      ifrz_q <= 1'b0;
    end else begin
      if (wr_cfg_i) cfg_q <= (cfg_q & lock) | (new_cfg_i & ~lock);
      // sticky until reset
      pfrz_q <= pfrz_q | set_pfrz_i;
      ifrz_q <= ifrz_q | set_ifrz_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign pfrz_o = pfrz_q;
  assign ifrz_o = ifrz_q;

endmodule

// File: rtl/cfgbank_group.sv
`timescale 1ns/1ps
module cfgbank_group
  import cfgbank_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_mask_i,
  input  logic                   we_cfg_i,
  input  logic                   we_frz_i,
  input  logic [31:0]            wdata_i,
  output logic [LINES-1:0]       mask_o,
  output logic [31:0]            rd_word_o,
  output logic [LINES*CFG_W-1:0] cfg_o,
  output logic [LINES-1:0]       pfrz_o,
  output logic [LINES-1:0]       ifrz_o
);

  logic [LINES-1:0] mask_q;
  line_cfg_t        new_cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (we_mask_i) mask_q <= wdata_i[LINES-1:0];
  end

  assign new_cfg = word_to_cfg(wdata_i);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    cfgbank_line u_line (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_cfg_i   (we_cfg_i & mask_q[i]),
      .new_cfg_i  (new_cfg),
      .set_pfrz_i (we_frz_i & mask_q[i] & wdata_i[FRZ_PHYS_BIT]),
      .set_ifrz_i (we_frz_i & mask_q[i] & wdata_i[FRZ_IRQ_BIT]),
      .cfg_o      (cfg_o[i*CFG_W +: CFG_W]),
      .pfrz_o     (pfrz_o[i]),
      .ifrz_o     (ifrz_o[i])
    );
  end

  // lowest masked line wins
  always_comb begin
    logic found;
    found     = 1'b0;
    rd_word_o = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!found && mask_q[i]) begin
        found     = 1'b1;
        rd_word_o = cfg_to_word(cfg_o[i*CFG_W +: CFG_W], pfrz_o[i], ifrz_o[i]);
      end
    end
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/cfgbank_top.sv
`timescale 1ns/1ps
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int LINES  = 32,
  parameter int ADDR_W = 9
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [31:0]                   wdata_i,
  output logic [31:0]                   rdata_o,
  output logic [GROUPS*LINES*CFG_W-1:0] cfg_o,
  output logic [GROUPS*LINES-1:0]       pfrz_o,
  output logic [GROUPS*LINES-1:0]       ifrz_o
);

  localparam int GSPAN  = 64;
  localparam int GSEL_W = ADDR_W - 6;
  localparam logic [ADDR_W-1:0] WP_ADDR = ADDR_W'(GROUPS * GSPAN);

  logic              wp_q;
  logic              in_grp;
  logic [GSEL_W-1:0] gsel;
  logic [5:0]        ofs;
  logic [LINES-1:0]  mask_a [GROUPS];
  logic [31:0]       rdw_a  [GROUPS];

  assign in_grp = addr_i < WP_ADDR;
  assign gsel   = addr_i[ADDR_W-1:6];
  assign ofs    = addr_i[5:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         wp_q <= 1'b0;
    else if (we_i && addr_i == WP_ADDR)  wp_q <= wdata_i[0];
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = we_i && in_grp && (gsel == GSEL_W'(g));

    cfgbank_group #(.LINES(LINES)) u_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_mask_i (hit && ofs == OFS_MASK),
      .we_cfg_i  (hit && ofs == OFS_CFG && !wp_q),
      .we_frz_i  (hit && ofs == OFS_FRZ),
      .wdata_i   (wdata_i),
      .mask_o    (mask_a[g]),
      .rd_word_o (rdw_a[g]),
      .cfg_o     (cfg_o[g*LINES*CFG_W +: LINES*CFG_W]),
      .pfrz_o    (pfrz_o[g*LINES +: LINES]),
      .ifrz_o    (ifrz_o[g*LINES +: LINES])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == WP_ADDR) rdata_o[0] = wp_q;
    for (int g = 0; g < GROUPS; g++) begin
      if (in_grp && gsel == GSEL_W'(g)) begin
        if (ofs == OFS_MASK)     rdata_o = 32'(mask_a[g]);
        else if (ofs == OFS_CFG) rdata_o = rdw_a[g];
      end
    end
  end

endmodule

// File: rtl/cfgbank_chk.sv
`timescale 1ns/1ps
module cfgbank_chk
  import cfgbank_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int LINES  = 32,
  parameter int ADDR_W = 9
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          we_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [31:0]                   rdata_o,
  input logic [GROUPS*LINES*CFG_W-1:0] cfg_o,
  input logic [GROUPS*LINES-1:0]       pfrz_o,
  input logic [GROUPS*LINES-1:0]       ifrz_o,
  input logic                          wp_q
);

  localparam int NL = GROUPS * LINES;
  localparam logic [ADDR_W-1:0] WP_ADDR = ADDR_W'(GROUPS * 64);

  logic [NL*CFG_W-1:0] pf_exp, if_exp;
  logic [NL-1:0]       clash;
  logic                cfg_addr;

  assign cfg_addr = (addr_i < WP_ADDR) && (addr_i[5:0] == OFS_CFG);

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      pf_exp[i*CFG_W +: CFG_W] = pfrz_o[i] ? PHYS_FIELDS : '0;
      if_exp[i*CFG_W +: CFG_W] = ifrz_o[i] ? IRQ_FIELDS  : '0;
      clash[i] = cfg_o[i*CFG_W + POS_PU] & cfg_o[i*CFG_W + POS_PD];
    end
  end

  assert_wp_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wp_q && cfg_addr) |=> $stable(cfg_o));

  assert_rsvd_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_addr |-> ((rdata_o & WORD_RSVD) == 32'h0));

  assert_phys_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((cfg_o ^ $past(cfg_o)) & $past(pf_exp)) == '0));

  assert_irq_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((cfg_o ^ $past(cfg_o)) & $past(if_exp)) == '0));

  assert_frz_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((pfrz_o & $past(pfrz_o)) == $past(pfrz_o)) &&
              ((ifrz_o & $past(ifrz_o)) == $past(ifrz_o))));

  assert_no_pull_clash_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash == '0);

endmodule

bind cfgbank_top cfgbank_chk #(
  .GROUPS(GROUPS), .LINES(LINES), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .cfg_o   (cfg_o),
  .pfrz_o  (pfrz_o),
  .ifrz_o  (ifrz_o),
  .wp_q    (wp_q)
);

// File: tb/tb_cfgbank_top.sv
`timescale 1ns/1ps
module tb_cfgbank_top;
  import cfgbank_pkg::*;

  localparam int GROUPS = 4;
  localparam int LINES  = 32;
  localparam int ADDR_W = 9;
  localparam logic [8:0] A_WP = 9'h100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [GROUPS*LINES*CFG_W-1:0] cfg_o;
  logic [GROUPS*LINES-1:0] pfrz_o, ifrz_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  cfgbank_top #(.GROUPS(GROUPS), .LINES(LINES), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cfg_o(cfg_o),
    .pfrz_o(pfrz_o), .ifrz_o(ifrz_o)
  );

  function automatic logic [8:0] a_mask(int g); return 9'(g*64);     endfunction
  function automatic logic [8:0] a_cfg(int g);  return 9'(g*64 + 4); endfunction
  function automatic logic [8:0] a_frz(int g);  return 9'(g*64 + 8); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic read_line(int g, int i, output logic [31:0] d);
    wr(a_mask(g), 32'h1 << i);
    rd(a_cfg(g), d);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    rd(A_WP, d);               check("R1 wp", d, 32'h0);
    for (int g = 0; g < GROUPS; g++) begin
      rd(a_mask(g), d);        check("R1 mask", d, 32'h0);
    end
    check("R1 cfg_o", 32'(|cfg_o), 32'h0);
    check("R1 freeze", 32'(|{pfrz_o, ifrz_o}), 32'h0);
    read_line(1, 7, d);        check("R1 line", d, 32'h0);
  endtask

  task automatic t_layout_pulls();
    logic [31:0] d;
    wr(a_mask(0), 32'h20);
    wr(a_cfg(0), 32'hFFFF_FFFF);
    rd(a_cfg(0), d);           check("R4 all ones", d, 32'h0703_F307);
    wr(a_cfg(0), 32'h0000_0400);
    rd(a_cfg(0), d);           check("R8 pd alone", d, 32'h0000_0400);
    wr(a_cfg(0), 32'h0000_0600);
    rd(a_cfg(0), d);           check("R8 pu and pd", d, 32'h0000_0200);
    wr(a_cfg(0), 32'h0000_0000);
  endtask

  task automatic t_masked_write();
    logic [31:0] d;
    wr(a_mask(1), 32'h0000_0011);
    rd(a_mask(1), d);          check("R3 mask readback", d, 32'h0000_0011);
    wr(a_cfg(1), 32'h0201_4103);
    read_line(1, 4, d);        check("R3 line4", d, 32'h0201_4103);
    read_line(1, 1, d);        check("R3 unmasked line1", d, 32'h0);
    read_line(2, 0, d);        check("R3 other group", d, 32'h0);
    wr(a_mask(1), 32'h1);
    wr(a_cfg(1), 32'h0000_0005);
    read_line(1, 4, d);        check("R3 line4 kept", d, 32'h0201_4103);
    read_line(1, 0, d);        check("R3 line0 new", d, 32'h0000_0005);
  endtask

  task automatic t_read_select();
    logic [31:0] d;
    wr(a_mask(2), 32'h0000_0C00);
    wr(a_cfg(2), 32'h0000_0001);
    wr(a_mask(2), 32'h0000_0800);
    wr(a_cfg(2), 32'h0000_0006);
    wr(a_mask(2), 32'h0000_0C00);
    rd(a_cfg(2), d);           check("R9 lowest line", d, 32'h0000_0001);
    wr(a_mask(2), 32'h0000_0800);
    rd(a_cfg(2), d);           check("R9 single line", d, 32'h0000_0006);
    wr(a_mask(2), 32'h0);
    rd(a_cfg(2), d);           check("R9 empty mask", d, 32'h0);
  endtask

  task automatic t_write_protect();
    logic [31:0] d;
    wr(a_mask(3), 32'h1);
    wr(a_cfg(3), 32'h0000_0103);
    wr(A_WP, 32'h1);
    rd(A_WP, d);               check("R2 lock reads 1", d, 32'h1);
    wr(a_cfg(3), 32'h0300_0004);
    rd(a_cfg(3), d);           check("R2 write blocked", d, 32'h0000_0103);
    wr(A_WP, 32'h0);
    wr(a_cfg(3), 32'h0300_0004);
    rd(a_cfg(3), d);           check("R2 unlocked write", d, 32'h0300_0004);
  endtask

  task automatic t_phys_freeze();
    logic [31:0] d;
    wr(a_mask(3), 32'h4);
    wr(a_cfg(3), 32'h0102_1102);
    wr(a_frz(3), 32'h1);
    rd(a_cfg(3), d);           check("R5 freeze status", d, 32'h2102_1102);
    check("R5 pfrz port", 32'(pfrz_o[3*LINES+2]), 32'h1);
    wr(a_cfg(3), 32'h0403_F607);
    rd(a_cfg(3), d);           check("R5 phys held, irq written", d, 32'h2402_3102);
  endtask

  task automatic t_irq_freeze();
    logic [31:0] d;
    wr(a_mask(0), 32'h200);
    wr(a_cfg(0), 32'h0200_1001);
    wr(a_frz(0), 32'h2);
    rd(a_cfg(0), d);           check("R6 freeze status", d, 32'h4200_1001);
    wr(a_cfg(0), 32'h0000_0305);
    rd(a_cfg(0), d);           check("R6 irq held, phys written", d, 32'h4200_1305);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    wr(a_mask(3), 32'h4);
    wr(a_frz(3), 32'h0);
    rd(a_cfg(3), d);           check("R7 zero cmd keeps flag", d[30:29], 32'h1);
    wr(a_mask(3), 32'h8);
    wr(a_frz(3), 32'h0);
    rd(a_cfg(3), d);           check("R7 zero cmd sets nothing", d[30:29], 32'h0);
    wr(a_mask(1), 32'h0);
    wr(a_frz(1), 32'h3);
    check("R7 empty mask", 32'(|pfrz_o[LINES +: LINES] | |ifrz_o[LINES +: LINES]), 32'h0);
    do_reset();
    check("R7 reset clears", 32'(|{pfrz_o, ifrz_o}), 32'h0);
    read_line(3, 2, d);        check("R1 after reset", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset_state();
    t_layout_pulls();
    t_masked_write();
    t_read_select();
    t_write_protect();
    t_phys_freeze();
    t_irq_freeze();
    t_sticky();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule